// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Width Packer

This block sits between a host register port and the sample sink of an audio link controller. Each host write carries one or two audio samples. The block widens every sample so that it is left-aligned in a 20-bit word, stores the result in a small circular buffer, and hands stereo pairs to a downstream sink. The older entry of each pair is the left sample. A pair moves on every cycle in which the sink is ready.

Draining is batched. A burst does not start until the buffer holds at least half its depth. Once started, it goes on one pair per cycle until the sink refuses a pair or fewer than two entries remain. Four status flags record what happened most recently: empty, half-empty, full and underrun. Three raw interrupt causes are derived from these flags. A per-cause enable mask produces the masked causes and a single interrupt line.

Top module: `audio_tx_queue`

## Requirements
- R1: In single mode one write stores one sample, taken from the low bits of the write word. `sizeCode` selects the width: 0 is 16 bits (shift left 4), 1 is 18 bits (shift left 2), 2 is 20 bits (no shift), 3 is 12 bits (shift left 8). The shifted value is truncated to 20 bits.
- R2: In packed mode (`compactReq`=1) one write stores two samples, bits 15:0 first and then bits 31:16. Each half is shifted left by 8 when `sizeCode`=3 and by 4 otherwise, then truncated to 20 bits.
- R3: Packed mode is ignored when `sizeCode` is 1 or 2. Such a write is stored as a single sample, exactly as in R1.
- R4: A single-mode write is accepted only while the level is below the depth. A packed write is accepted only while the level plus 2 is strictly below the depth. A rejected write leaves the level and the contents unchanged. `fillLevel` reports the entry count.
- R5: A pair is offered (`pairValid`=1) only while `chanEn`=1, at least one bit of `slotMask` is set, and the level is at least 2. A new burst also needs the level to be at least half the depth. A pair is removed in each cycle in which it is offered and `sinkReady`=1, and that transfer keeps the burst going. A refused pair ends the burst. `pairLeft` is the oldest entry and `pairRight` the next one.
- R6: After a cycle with an accepted write, the flags update as follows: empty and underrun are cleared; half-empty is cleared if the new level is at least half the depth; full is set if the new level equals the depth.
- R7: After a cycle with a pair removal, full is cleared. Half-empty is set if the new level is at most half the depth. If the new level is zero, empty and underrun are both set. These updates take priority over those of R6.
- R8: `clrUnderrun`=1 clears the underrun flag. If the same cycle drains the buffer to zero, the flag is set instead.
- R9: `rawInt` bit 0 is the underrun flag, bit 1 is the half-empty flag, and bit 2 is empty while no pair is being offered.
- R10: `maskedInt` is `rawInt` ANDed with `intMask`, and `irq` is high when any bit of `maskedInt` is set.
- R11: After reset the level is 0, empty and half-empty are 1, full and underrun are 0, and no pair is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe for the sample port |
| wrData | input | WORD_W | Host write word |
| chanEn | input | 1 | Channel transmit enable |
| slotMask | input | 2 | Data slot enables; draining needs at least one |
| compactReq | input | 1 | Requests packed mode (two samples per word) |
| sizeCode | input | 2 | Sample width code |
| clrUnderrun | input | 1 | Clears the underrun flag |
| intMask | input | 3 | Enable mask for the interrupt causes |
| sinkReady | input | 1 | Sink accepts the offered pair |
| pairValid | output | 1 | A stereo pair is offered |
| pairLeft | output | SAMPLE_W | Left (older) sample |
| pairRight | output | SAMPLE_W | Right (newer) sample |
| fillLevel | output | clog2(DEPTH+1) | Number of stored entries |
| statusEmpty | output | 1 | Empty flag |
| statusHalf | output | 1 | Half-empty flag |
| statusFull | output | 1 | Full flag |
| statusUnder | output | 1 | Underrun flag |
| rawInt | output | 3 | Raw interrupt causes |
| maskedInt | output | 3 | Causes after the enable mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default depth of 8 and a 32-bit write word. With this depth, eight single writes fill the queue, and a packed write is already refused at a level of 6. Overrun rejection, the strict packed-mode limit, the half-depth start of a burst and draining to empty all happen within a few dozen cycles, which leaves the long pseudo-random phase free to wrap the pointers many times and to mix writes, refusals, clears and removals in the same cycle.

// File: rtl/audio_txq_pkg.sv
package audio_txq_pkg;

  typedef struct packed {
    logic pushOne;
    logic pushTwo;
    logic popPair;
  } txq_strobe_t;

  function automatic logic packed_allowed(input logic req, input logic [1:0] code);
    return req && ((code == 2'd0) || (code == 2'd3));
  endfunction

  function automatic logic [3:0] single_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd4;
      2'd1:    return 4'd2;
      2'd2:    return 4'd0;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] packed_shift(input logic [1:0] code);
    return (code == 2'd3) ? 4'd8 : 4'd4;
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store
  import audio_txq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SAMPLE_W = 20,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  txq_strobe_t         stb,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [1:0]          sizeCode,
  output logic [SAMPLE_W-1:0] pairLeft,
  output logic [SAMPLE_W-1:0] pairRight
);
  localparam int AW     = $clog2(DEPTH);
  localparam int HALF_W = WORD_W / 2;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0]       wrPtr, rdPtr, wrPtrNext1, rdPtrNext1;
  logic [WORD_W-1:0]   singleWide, loWide, hiWide;
  logic [SAMPLE_W-1:0] firstVal, secondVal;

  // packer: widen to a left-aligned sample, truncated to SAMPLE_W
  assign singleWide = wrData << single_shift(sizeCode);
  assign loWide     = WORD_W'(wrData[HALF_W-1:0]) << packed_shift(sizeCode);
  assign hiWide     = WORD_W'(wrData[WORD_W-1:HALF_W]) << packed_shift(sizeCode);
  assign firstVal   = stb.pushTwo ? loWide[SAMPLE_W-1:0] : singleWide[SAMPLE_W-1:0];
  assign secondVal  = hiWide[SAMPLE_W-1:0];

  assign wrPtrNext1 = wrPtr + AW'(1);
  assign rdPtrNext1 = rdPtr + AW'(1);

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if ((stb.pushOne || stb.pushTwo) && (wrPtr == AW'(i)))
        mem[i] <= firstVal;
      else if (stb.pushTwo && (wrPtrNext1 == AW'(i)))
        mem[i] <= secondVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.pushTwo)      wrPtr <= wrPtr + AW'(2);
      else if (stb.pushOne) wrPtr <= wrPtrNext1;
      if (stb.popPair)      rdPtr <= rdPtr + AW'(2);
    end
  end

  assign pairLeft  = mem[rdPtr];
  assign pairRight = mem[rdPtrNext1];

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import audio_txq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          chanEn,
  input  logic [1:0]    slotMask,
  input  logic          compactReq,
  input  logic [1:0]    sizeCode,
  input  logic          clrUnderrun,
  input  logic [2:0]    intMask,
  input  logic          sinkReady,
  output txq_strobe_t   stb,
  output logic          pairValid,
  output logic [LW-1:0] level,
  output logic          statusEmpty,
  output logic          statusHalf,
  output logic          statusFull,
  output logic          statusUnder,
  output logic [2:0]    rawInt,
  output logic [2:0]    maskedInt,
  output logic          irq
);
  localparam int HALF = DEPTH / 2;

  logic          burst, offer, accept, packedEff;
  logic [LW-1:0] lvlNext;

  assign packedEff = packed_allowed(compactReq, sizeCode);
  assign accept    = wrEn && (packedEff ? (int'(level) + 2 < DEPTH)
                                        : (int'(level) < DEPTH));
  assign offer     = chanEn && (|slotMask) && (level >= LW'(2))
                     && (burst || (level >= LW'(HALF)));

  assign stb.pushOne = accept && !packedEff;
  assign stb.pushTwo = accept && packedEff;
  assign stb.popPair = offer && sinkReady;
  assign pairValid   = offer;

  assign lvlNext = level
                 + (stb.pushOne ? LW'(1) : LW'(0))
                 + (stb.pushTwo ? LW'(2) : LW'(0))
                 - (stb.popPair ? LW'(2) : LW'(0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level       <= '0;
      burst       <= 1'b0;
      statusEmpty <= 1'b1;
      statusHalf  <= 1'b1;
      statusFull  <= 1'b0;
      statusUnder <= 1'b0;
    end else begin
      level <= lvlNext;
      burst <= stb.popPair;
      if (clrUnderrun) statusUnder <= 1'b0;
      if (accept) begin
        if (lvlNext != '0) begin
          statusEmpty <= 1'b0;
          statusUnder <= 1'b0;
        end
        if (lvlNext >= LW'(HALF))  statusHalf <= 1'b0;
        if (lvlNext == LW'(DEPTH)) statusFull <= 1'b1;
      end
      if (stb.popPair) begin
        statusFull <= 1'b0;
        if (lvlNext <= LW'(HALF)) statusHalf <= 1'b1;
        if (lvlNext == '0) begin
          statusEmpty <= 1'b1;
          statusUnder <= 1'b1;
        end
      end
    end
  end

  assign rawInt    = {statusEmpty && !offer, statusHalf, statusUnder};
  assign maskedInt = rawInt & intMask;
  assign irq       = |maskedInt;

  // R4: the level never exceeds the depth
  p_level_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));

  // R4: a write while full never raises the level
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && level == LW'(DEPTH)) |=> level <= $past(level));

  // R5: a burst can only begin at or above half depth
  p_burst_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pairValid) |-> level >= LW'(HALF));

  // R7: the empty flag only stands with nothing stored
  p_empty_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusEmpty |-> level == '0);

  // R6: the full flag only stands with the queue at depth
  p_full_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusFull |-> level == LW'(DEPTH));

endmodule

// File: rtl/audio_tx_queue.sv
module audio_tx_queue
  import audio_txq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SAMPLE_W = 20,
  parameter int WORD_W   = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [WORD_W-1:0]            wrData,
  input  logic                         chanEn,
  input  logic [1:0]                   slotMask,
  input  logic                         compactReq,
  input  logic [1:0]                   sizeCode,
  input  logic                         clrUnderrun,
  input  logic [2:0]                   intMask,
  input  logic                         sinkReady,
  output logic                         pairValid,
  output logic [SAMPLE_W-1:0]          pairLeft,
  output logic [SAMPLE_W-1:0]          pairRight,
  output logic [$clog2(DEPTH+1)-1:0]   fillLevel,
  output logic                         statusEmpty,
  output logic                         statusHalf,
  output logic                         statusFull,
  output logic                         statusUnder,
  output logic [2:0]                   rawInt,
  output logic [2:0]                   maskedInt,
  output logic                         irq
);
  localparam int LW = $clog2(DEPTH + 1);

  txq_strobe_t stb;

  txq_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .chanEn(chanEn), .slotMask(slotMask),
    .compactReq(compactReq), .sizeCode(sizeCode), .clrUnderrun(clrUnderrun),
    .intMask(intMask), .sinkReady(sinkReady), .stb(stb), .pairValid(pairValid),
    .level(fillLevel), .statusEmpty(statusEmpty), .statusHalf(statusHalf),
    .statusFull(statusFull), .statusUnder(statusUnder), .rawInt(rawInt),
    .maskedInt(maskedInt), .irq(irq)
  );

  txq_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .sizeCode(sizeCode),
    .pairLeft(pairLeft), .pairRight(pairRight)
  );

endmodule

// File: tb/sim_audio_tx_queue.sv
`timescale 1ns/1ps
module sim_audio_tx_queue;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, wrEn = 1'b0, chanEn = 1'b0, compactReq = 1'b0;
  logic clrUnderrun = 1'b0, sinkReady = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  slotMask = '0, sizeCode = '0;
  logic [2:0]  intMask = '0;
  logic        pairValid, statusEmpty, statusHalf, statusFull, statusUnder, irq;
  logic [19:0] pairLeft, pairRight;
  logic [LW-1:0] fillLevel;
  logic [2:0]  rawInt, maskedInt;

  audio_tx_queue #(.DEPTH(DEPTH)) u0 (.*);

  int total = 0, bad = 0;
  int q[$];
  bit mEmpty, mHalf, mFull, mUnder, mBurst;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit offer_now();
    int lvl = q.size();
    return chanEn && (slotMask != 0) && lvl >= 2 && (mBurst || lvl >= DEPTH / 2);
  endfunction

  function automatic int widen_single(int v, int code);
    case (code)
      0: return (v << 4) & 'hFFFFF;
      1: return (v << 2) & 'hFFFFF;
      2: return v & 'hFFFFF;
      default: return (v << 8) & 'hFFFFF;
    endcase
  endfunction

  function automatic int widen_half(int h, int code);
    return (h << ((code == 3) ? 8 : 4)) & 'hFFFFF;
  endfunction

  task automatic compare();
    bit go = offer_now();
    int raw = {29'd0, mEmpty && !go, mHalf, mUnder};
    check("R4 fill level", int'(fillLevel), q.size());
    check("R5 pair offered", int'(pairValid), int'(go));
    if (go) begin
      check("R1/R2/R3/R5 left sample", int'(pairLeft), q[0]);
      check("R1/R2/R3/R5 right sample", int'(pairRight), q[1]);
    end
    check("R6/R7 empty flag", int'(statusEmpty), int'(mEmpty));
    check("R6/R7 half flag", int'(statusHalf), int'(mHalf));
    check("R6/R7 full flag", int'(statusFull), int'(mFull));
    check("R7/R8 underrun flag", int'(statusUnder), int'(mUnder));
    check("R9 raw causes", int'(rawInt), raw);
    check("R10 masked causes", int'(maskedInt), raw & int'(intMask));
    check("R10 irq line", int'(irq), int'((raw & int'(intMask)) != 0));
  endtask

  task automatic model_step();
    int lvl = q.size();
    bit comp = compactReq && (sizeCode == 0 || sizeCode == 3);
    bit go = offer_now();
    bit pop = go && sinkReady;
    bit acc = wrEn && (comp ? (lvl + 2 < DEPTH) : (lvl < DEPTH));
    int nl;
    if (pop) begin
      void'(q.pop_front());
      void'(q.pop_front());
    end
    if (acc) begin
      if (comp) begin
        q.push_back(widen_half(int'(wrData[15:0]), int'(sizeCode)));
        q.push_back(widen_half(int'(wrData[31:16]), int'(sizeCode)));
      end else begin
        q.push_back(widen_single(int'(wrData), int'(sizeCode)));
      end
    end
    nl = q.size();
    if (clrUnderrun) mUnder = 0;
    if (acc) begin
      if (nl != 0) begin mEmpty = 0; mUnder = 0; end
      if (nl >= DEPTH / 2) mHalf = 0;
      if (nl == DEPTH) mFull = 1;
    end
    if (pop) begin
      mFull = 0;
      if (nl <= DEPTH / 2) mHalf = 1;
      if (nl == 0) begin mEmpty = 1; mUnder = 1; end
    end
    mBurst = pop;
  endtask

  task automatic cycle();
    #2;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic put(input logic [31:0] d, input logic [1:0] code, input logic cmp);
    wrEn = 1; wrData = d; sizeCode = code; compactReq = cmp;
    cycle();
    wrEn = 0;
  endtask

  bit finished = 0;

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    q.delete();
    mEmpty = 1; mHalf = 1; mFull = 0; mUnder = 0; mBurst = 0;
    #2;
    // R11: reset state
    check("R11 reset level", int'(fillLevel), 0);
    check("R11 reset empty", int'(statusEmpty), 1);
    check("R11 reset half", int'(statusHalf), 1);
    check("R11 reset full", int'(statusFull), 0);
    check("R11 reset underrun", int'(statusUnder), 0);
    check("R11 reset no pair", int'(pairValid), 0);
    @(negedge clk);
    intMask = 3'b111;

    // R1: each width code, disabled channel, then overrun (R4)
    put(32'h0000_ABCD, 2'd0, 0);
    put(32'h0003_FFFF, 2'd1, 0);
    put(32'hFFF1_2345, 2'd2, 0);
    put(32'h0000_0FED, 2'd3, 0);
    put(32'hFFFF_FFFF, 2'd3, 0);
    put(32'h0001_2345, 2'd0, 0);
    put(32'h0002_5A5A, 2'd1, 0);
    put(32'h000F_0F0F, 2'd2, 0);
    put(32'h0000_1111, 2'd0, 0);   // R4: dropped at full
    cycle();
    // R5: enabled but no slot bit -> nothing offered
    chanEn = 1; sinkReady = 1;
    repeat (2) cycle();
    // R5: drain with refusal in the middle
    slotMask = 2'b10;
    cycle();
    sinkReady = 0; repeat (2) cycle();
    sinkReady = 1; repeat (4) cycle();
    // R8: clear underrun
    clrUnderrun = 1; cycle(); clrUnderrun = 0;

    // R2/R3: packed modes, and packed request ignored for 18/20-bit
    chanEn = 0;
    put(32'h1234_ABCD, 2'd0, 1);
    put(32'h0FED_0123, 2'd3, 1);
    put(32'h0003_FFFF, 2'd1, 1);
    put(32'h000A_BCDE, 2'd2, 1);
    put(32'h5555_AAAA, 2'd0, 1);   // R4: level 6, 6+2 not below 8 -> dropped
    put(32'h0000_0777, 2'd0, 0);
    put(32'h0000_0888, 2'd0, 0);
    cycle();
    chanEn = 1; slotMask = 2'b01; sinkReady = 1;
    repeat (5) cycle();

    // mixed pseudo-random phase
    for (int i = 0; i < 4000; i++) begin
      wrEn        = ($urandom % 2) == 0;
      wrData      = $urandom;
      compactReq  = $urandom % 2;
      sizeCode    = $urandom % 4;
      chanEn      = ($urandom % 8) != 0;
      slotMask    = $urandom % 4;
      sinkReady   = ($urandom % 4) != 0;
      clrUnderrun = ($urandom % 10) == 0;
      intMask     = $urandom % 8;
      cycle();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule